// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block gathers interrupt requests from a parameterised set of sources on behalf of a small 8-bit processor. It decides which request to serve and hands the processor a vector number through a valid/acknowledge handshake. Each source is built either as an event source or as a level source, chosen by a per-bit mask parameter. An event source keeps a pending flag until the request is served or software clears it. A level source asks for service only while its input is held high.

A global enable gates every acceptance. Software sets the enable with a set pulse or a return-from-interrupt pulse, and clears it with a clear pulse. Acceptance clears the enable itself. The processor marks each point where it is about to begin a new instruction, and it reports when it is asleep. The controller accepts a request only at one of these points. Once it has accepted a request, it counts a fixed response time before it presents the vector, and the count is longer when the processor was asleep. After a return, and after a set of the enable, one further instruction always runs before the next acceptance.

Vector numbers begin at 1 for source 0. Vector 0 belongs to reset, which lies outside this block.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Among enabled pending sources the one with the lowest index wins, and `vec_idx` carries that index plus one; vector 0 is never issued.
- R2: An event source whose `irq_i` bit is high in a cycle has its `flags_o` bit set in the next cycle, whatever the enable bits and the global enable are; the bit stays set until R3 clears it.
- R3: An event flag is cleared in the cycle after its source is accepted, or after a cycle in which its `flag_clr` bit is one; a new event in the same cycle as a clear keeps the flag set.
- R4: A level source (its `LEVEL_MASK` bit is 1) always reads 0 in `flags_o` and is pending only while its `irq_i` bit and its enable bit are both high; a request that drops before it is enabled is never served.
- R5: Accepting a request clears `gie_o` in the next cycle.
- R6: A `reti` or `gie_set` pulse sets `gie_o` in the next cycle, unless `gie_clr` is high in the same cycle.
- R7: After a `reti` or `gie_set` pulse, the next instruction boundary (a cycle with `insn_start` or `sleep_i` high) is never an acceptance; the earliest possible acceptance is the boundary after that.
- R8: Acceptance needs a boundary cycle, `gie_o` high, an enabled pending source and no vector outstanding. `vec_valid` rises `RESP_CYC` (default 4) cycles after the acceptance cycle, or `RESP_CYC + WAKE_CYC` (default 8) cycles after it when `sleep_i` is high in that cycle.
- R9: A cycle with `gie_clr` high is never an acceptance, even when a request and a boundary arrive in that same cycle, and `gie_o` is low in the next cycle.
- R10: `vec_valid` and `vec_idx` hold steady until a cycle with `vec_ack` high, and `vec_valid` is low in the cycle after the acknowledge.
- R11: A cycle with `en_we` high loads `en_wdata` into the enable register, which `en_o` shows from the next cycle; a source whose enable bit is 0 is never accepted.
- R12: When several flags are pending, each return followed by its guard instruction serves the next one in priority order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | N_SRC | Request inputs (pulse for event sources, level for level sources) |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | N_SRC | Enable register write data |
| en_o | output | N_SRC | Enable register contents |
| flag_clr | input | N_SRC | Write-one-to-clear strobes for the pending flags |
| flags_o | output | N_SRC | Pending flags of the event sources |
| gie_set | input | 1 | Global enable set pulse |
| gie_clr | input | 1 | Global enable clear pulse, takes effect in the same cycle |
| reti | input | 1 | Return-from-interrupt pulse |
| gie_o | output | 1 | Global enable state |
| insn_start | input | 1 | Processor is about to begin a new instruction |
| sleep_i | input | 1 | Processor is asleep; also acts as a boundary |
| vec_valid | output | 1 | Vector available to the processor |
| vec_idx | output | $clog2(N_SRC+1) | Vector number of the served source |
| vec_ack | input | 1 | Processor has taken the vector |

## Verification
Flags and the global enable change one cycle after the strobe that causes them. The vector appears exactly 4 cycles after the acceptance cycle, or 8 cycles after it when the processor is asleep. The bench drives its stimulus just after a rising edge and reads the outputs half a nanosecond after the edge. After each accepting boundary it steps the exact number of edges and checks that `vec_valid` is still low one cycle before it is due and high in the cycle it is due. A behavioural model that counts the cycles since acceptance is compared with every output on every clock, so the guard cycle after a return and the blocked boundary after an enable set are checked to the cycle.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  // Total response length in cycles, counted from the acceptance cycle.
  function automatic int unsigned resp_len(input logic from_sleep,
                                           input int unsigned base,
                                           input int unsigned wake);
    return from_sleep ? base + wake : base;
  endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 8,
  parameter logic [N-1:0] LEVEL_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_i,
  input  logic [N-1:0] en,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] served,
  output logic [N-1:0] flags,
  output logic [N-1:0] pend
);

  for (genvar i = 0; i < N; i++) begin : g_src
    if (LEVEL_MASK[i]) begin : g_lvl
      // live request, nothing remembered
      assign flags[i] = 1'b0;
      assign pend[i]  = en[i] & irq_i[i];
    end else begin : g_evt
      logic fq;
      always_ff @(posedge clk) begin
        if (!rst_n)                  fq <= 1'b0;
        else if (irq_i[i])           fq <= 1'b1;   // new event beats a clear
        else if (clr[i] | served[i]) fq <= 1'b0;
      end
      assign flags[i] = fq;
      assign pend[i]  = en[i] & fq;
    end
  end

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N  = 8,
  parameter int VW = 4
) (
  input  logic [N-1:0]  pend,
  output logic          any,
  output logic [VW-1:0] vec,
  output logic [N-1:0]  oh
);

  // scan from the top so the lowest index is written last and wins
  always_comb begin
    any = 1'b0;
    vec = '0;
    oh  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        any   = 1'b1;
        vec   = VW'(i + 1);
        oh    = '0;
        oh[i] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_prio_pkg::*;
#(
  parameter int RESP = 4,
  parameter int WAKE = 4,
  parameter int VW   = 4,
  parameter int LW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          any_pend,
  input  logic [VW-1:0] win_vec,
  input  logic          boundary,
  input  logic          sleep_i,
  input  logic          gie_set,
  input  logic          gie_clr,
  input  logic          reti,
  input  logic          vec_ack,
  output logic          accept,
  output logic          gie,
  output logic          vec_valid,
  output logic [VW-1:0] vec_idx,
  output logic          busy
);

  logic          gie_q, hold_q, busy_q;
  logic [LW-1:0] left_q;
  logic [VW-1:0] idx_q;

  assign accept    = !busy_q && gie_q && !gie_clr && !hold_q && boundary && any_pend;
  assign vec_valid = busy_q && (left_q == '0);
  assign vec_idx   = idx_q;
  assign gie       = gie_q;
  assign busy      = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      if (accept || gie_clr)   gie_q <= 1'b0;
      else if (gie_set || reti) gie_q <= 1'b1;

      if (gie_set || reti) hold_q <= 1'b1;   // guard the next instruction
      else if (boundary)   hold_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      left_q <= '0;
      idx_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      left_q <= LW'(resp_len(sleep_i, RESP, WAKE) - 1);
      idx_q  <= win_vec;
    end else if (busy_q) begin
      if (left_q != '0) left_q <= left_q - 1'b1;
      else if (vec_ack) busy_q <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int N_SRC = 8,
  parameter logic [N_SRC-1:0] LEVEL_MASK = 'hC0,
  parameter int RESP_CYC = 4,
  parameter int WAKE_CYC = 4,
  localparam int VW = $clog2(N_SRC + 1),
  localparam int LW = $clog2(RESP_CYC + WAKE_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_i,
  input  logic             en_we,
  input  logic [N_SRC-1:0] en_wdata,
  output logic [N_SRC-1:0] en_o,
  input  logic [N_SRC-1:0] flag_clr,
  output logic [N_SRC-1:0] flags_o,
  input  logic             gie_set,
  input  logic             gie_clr,
  input  logic             reti,
  output logic             gie_o,
  input  logic             insn_start,
  input  logic             sleep_i,
  output logic             vec_valid,
  output logic [VW-1:0]    vec_idx,
  input  logic             vec_ack
);

  logic [N_SRC-1:0] en_q, pend, win_oh, served;
  logic [VW-1:0]    win_vec;
  logic             any_pend, accept, busy, boundary;

  always_ff @(posedge clk) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= en_wdata;
  end
  assign en_o = en_q;

  assign boundary = insn_start | sleep_i;
  assign served   = win_oh & {N_SRC{accept}};

  irq_flag_bank #(.N(N_SRC), .LEVEL_MASK(LEVEL_MASK)) u_flags (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .en(en_q), .clr(flag_clr),
    .served(served), .flags(flags_o), .pend(pend)
  );

  irq_pick #(.N(N_SRC), .VW(VW)) u_pick (
    .pend(pend), .any(any_pend), .vec(win_vec), .oh(win_oh)
  );

  irq_seq #(.RESP(RESP_CYC), .WAKE(WAKE_CYC), .VW(VW), .LW(LW)) u_seq (
    .clk(clk), .rst_n(rst_n), .any_pend(any_pend), .win_vec(win_vec),
    .boundary(boundary), .sleep_i(sleep_i), .gie_set(gie_set),
    .gie_clr(gie_clr), .reti(reti), .vec_ack(vec_ack), .accept(accept),
    .gie(gie_o), .vec_valid(vec_valid), .vec_idx(vec_idx), .busy(busy)
  );

endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk #(
  parameter int N = 8,
  parameter logic [N-1:0] LEVEL_MASK = '0,
  parameter int RESP = 4,
  parameter int WAKE = 4,
  parameter int VW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  irq_i,
  input logic [N-1:0]  flag_clr,
  input logic [N-1:0]  flags_o,
  input logic          gie_set,
  input logic          gie_clr,
  input logic          reti,
  input logic          gie_o,
  input logic          sleep_i,
  input logic          vec_valid,
  input logic [VW-1:0] vec_idx,
  input logic          vec_ack,
  input logic          accept,
  input logic          busy
);

  localparam logic [N-1:0] EVT = ~LEVEL_MASK;

  int unsigned since_q, lat_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_q <= 0;
      lat_q   <= 0;
    end else if (accept) begin
      since_q <= 1;
      lat_q   <= sleep_i ? RESP + WAKE : RESP;
    end else if (busy && !vec_valid) begin
      since_q <= since_q + 1;
    end
  end

  a_r5_entry_clears_gie: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !gie_o);

  a_r6_return_sets_gie: assert property (@(posedge clk) disable iff (!rst_n)
    ((reti || gie_set) && !gie_clr && !accept) |=> gie_o);

  a_r7_guard_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (reti || gie_set) |=> !accept);

  a_r9_clear_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    gie_clr |-> (!accept ##1 !gie_o));

  a_r10_vector_held: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ack) |=> (vec_valid && $stable(vec_idx)));

  a_r1_no_reset_vector: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_idx != '0));

  a_r8_response_time: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_valid) |-> (since_q == lat_q));

  a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flag_clr & ~irq_i & EVT)) |=> ((flags_o & $past(flag_clr & ~irq_i & EVT)) == '0));

  a_r4_level_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o & LEVEL_MASK) == '0);

endmodule

bind irq_prio_ctrl irq_prio_chk #(
  .N(N_SRC), .LEVEL_MASK(LEVEL_MASK), .RESP(RESP_CYC), .WAKE(WAKE_CYC), .VW(VW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .flag_clr(flag_clr),
  .flags_o(flags_o), .gie_set(gie_set), .gie_clr(gie_clr), .reti(reti),
  .gie_o(gie_o), .sleep_i(sleep_i), .vec_valid(vec_valid), .vec_idx(vec_idx),
  .vec_ack(vec_ack), .accept(accept), .busy(busy)
);

// File: tb/irq_prio_ctrl_test.sv
`timescale 1ns/100ps
module irq_prio_ctrl_test;

  localparam int N = 8;
  localparam logic [N-1:0] LVL = 8'hC0;
  localparam int RESP = 4, WAKE = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] irq_i = '0, en_wdata = '0, flag_clr = '0;
  logic en_we = 0, gie_set = 0, gie_clr = 0, reti = 0;
  logic insn_start = 0, sleep_i = 0, vec_ack = 0;
  logic [N-1:0] en_o, flags_o;
  logic gie_o, vec_valid;
  logic [3:0] vec_idx;

  always #2.5 clk = ~clk;

  irq_prio_ctrl #(.N_SRC(N), .LEVEL_MASK(LVL), .RESP_CYC(RESP), .WAKE_CYC(WAKE)) uut (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .en_we(en_we), .en_wdata(en_wdata),
    .en_o(en_o), .flag_clr(flag_clr), .flags_o(flags_o), .gie_set(gie_set),
    .gie_clr(gie_clr), .reti(reti), .gie_o(gie_o), .insn_start(insn_start),
    .sleep_i(sleep_i), .vec_valid(vec_valid), .vec_idx(vec_idx), .vec_ack(vec_ack)
  );

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  bit [N-1:0] m_fl, m_en;
  bit m_gie, m_guard, m_busy, m_sleepacc;
  int m_since, m_vec;

  function automatic bit m_valid();
    return m_busy && (m_since >= (m_sleepacc ? RESP + WAKE : RESP));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_fl = '0; m_en = '0; m_gie = 0; m_guard = 0; m_busy = 0;
      m_since = 0; m_vec = 0; m_sleepacc = 0;
    end else begin
      int best;
      bit at_bnd, take, was_valid;
      best = -1;
      for (int i = 0; i < N; i++)
        if (best < 0 && m_en[i] && (LVL[i] ? irq_i[i] : m_fl[i])) best = i;
      at_bnd = insn_start || sleep_i;
      take = !m_busy && m_gie && !gie_clr && !m_guard && at_bnd && best >= 0;
      was_valid = m_valid();
      for (int i = 0; i < N; i++) begin
        if (!LVL[i]) begin
          if (irq_i[i]) m_fl[i] = 1;
          else if (flag_clr[i] || (take && best == i)) m_fl[i] = 0;
        end
      end
      if (take || gie_clr) m_gie = 0;
      else if (gie_set || reti) m_gie = 1;
      if (gie_set || reti) m_guard = 1;
      else if (at_bnd) m_guard = 0;
      if (take) begin
        m_busy = 1; m_since = 1; m_vec = best + 1; m_sleepacc = sleep_i;
      end else if (m_busy) begin
        if (was_valid && vec_ack) m_busy = 0;
        else if (!was_valid) m_since++;
      end
      if (en_we) m_en = en_wdata;
    end
    #0.5;
    if (rst_n && !finished) begin
      chk(flags_o == m_fl, "R2", "model flags", flags_o, m_fl);
      chk(gie_o == m_gie, "R5", "model gie", gie_o, m_gie);
      chk(vec_valid == m_valid(), "R8", "model vec_valid", vec_valid, m_valid());
      if (m_valid()) chk(vec_idx == m_vec, "R1", "model vec_idx", vec_idx, m_vec);
    end
  end

  task automatic nx(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    chk(0, "WDOG", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    nx(3);
    rst_n = 1;
    nx();
    chk(flags_o == 0 && gie_o == 0 && vec_valid == 0 && en_o == 0, "R11",
        "reset state", {flags_o, en_o}, 0);

    // R2: event latched while disabled
    irq_i[3] = 1; nx(); irq_i[3] = 0;
    chk(flags_o == 8'h08, "R2", "flag set while disabled", flags_o, 8'h08);
    insn_start = 1; nx(3); insn_start = 0;
    chk(flags_o == 8'h08 && !vec_valid, "R2", "flag kept", flags_o, 8'h08);

    // R3: event beats clear, then clear alone
    irq_i[3] = 1; flag_clr[3] = 1; nx(); irq_i[3] = 0;
    chk(flags_o == 8'h08, "R3", "event beats clear", flags_o, 8'h08);
    nx(); flag_clr[3] = 0;
    chk(flags_o == 8'h00, "R3", "write one clears", flags_o, 0);

    // R11, R1, R7, R5, R8, R10, R6, R12
    irq_i = 8'h24; nx(); irq_i = 0;
    en_we = 1; en_wdata = 8'hFF; nx(); en_we = 0;
    chk(en_o == 8'hFF, "R11", "enable load", en_o, 8'hFF);
    gie_set = 1; nx(); gie_set = 0;
    chk(gie_o == 1, "R6", "gie_set", gie_o, 1);
    insn_start = 1; nx(); insn_start = 0;
    chk(flags_o == 8'h24, "R7", "guard after gie_set", flags_o, 8'h24);
    insn_start = 1; nx(); insn_start = 0;
    chk(flags_o == 8'h20, "R3", "served flag cleared", flags_o, 8'h20);
    chk(gie_o == 0, "R5", "entry clears gie", gie_o, 0);
    nx(2);
    chk(vec_valid == 0, "R8", "not early", vec_valid, 0);
    nx();
    chk(vec_valid == 1 && vec_idx == 3, "R1", "lowest wins", vec_idx, 3);
    insn_start = 1; nx(3); insn_start = 0;
    chk(vec_valid == 1 && vec_idx == 3, "R10", "held until ack", vec_idx, 3);
    vec_ack = 1; nx(); vec_ack = 0;
    chk(vec_valid == 0, "R10", "drops after ack", vec_valid, 0);
    reti = 1; nx(); reti = 0;
    chk(gie_o == 1, "R6", "reti sets gie", gie_o, 1);
    insn_start = 1; nx(); insn_start = 0;
    chk(flags_o == 8'h20, "R7", "guard after reti", flags_o, 8'h20);
    insn_start = 1; nx(); insn_start = 0;
    chk(flags_o == 8'h00, "R12", "next in order taken", flags_o, 0);
    nx(3);
    chk(vec_valid == 1 && vec_idx == 6, "R12", "second vector", vec_idx, 6);
    vec_ack = 1; nx(); vec_ack = 0;
    reti = 1; nx(); reti = 0;
    insn_start = 1; nx(); insn_start = 0;

    // R8: wake from sleep
    irq_i[1] = 1; nx(); irq_i[1] = 0;
    sleep_i = 1; nx(); sleep_i = 0;
    chk(flags_o[1] == 0, "R8", "accepted in sleep", flags_o[1], 0);
    nx(6);
    chk(vec_valid == 0, "R8", "sleep not early", vec_valid, 0);
    nx();
    chk(vec_valid == 1 && vec_idx == 2, "R8", "sleep latency", vec_idx, 2);
    vec_ack = 1; nx(); vec_ack = 0;
    reti = 1; nx(); reti = 0;
    insn_start = 1; nx(); insn_start = 0;

    // R9: clear in the same cycle as a request
    irq_i[0] = 1; nx(); irq_i[0] = 0;
    gie_clr = 1; insn_start = 1; nx(); gie_clr = 0; insn_start = 0;
    chk(gie_o == 0 && flags_o[0] == 1, "R9", "clear blocks", flags_o, 1);
    nx(5);
    chk(vec_valid == 0, "R9", "no vector", vec_valid, 0);
    flag_clr[0] = 1; nx(); flag_clr[0] = 0;

    // R4 / R11: level sources
    gie_set = 1; nx(); gie_set = 0;
    insn_start = 1; nx(); insn_start = 0;
    en_we = 1; en_wdata = 8'hBF; nx(); en_we = 0;
    irq_i[6] = 1; insn_start = 1; nx(3); insn_start = 0;
    chk(flags_o == 0, "R4", "level has no flag", flags_o, 0);
    nx(4);
    chk(vec_valid == 0 && gie_o == 1, "R11", "disabled not taken", vec_valid, 0);
    irq_i[6] = 0; nx();
    en_we = 1; en_wdata = 8'hFF; nx(); en_we = 0;
    insn_start = 1; nx(3); insn_start = 0;
    nx(4);
    chk(vec_valid == 0 && gie_o == 1, "R4", "dropped level ignored", vec_valid, 0);
    irq_i[7] = 1; insn_start = 1; nx(); insn_start = 0;
    chk(gie_o == 0, "R4", "level accepted", gie_o, 0);
    nx(3);
    chk(vec_valid == 1 && vec_idx == 8, "R4", "level vector", vec_idx, 8);
    irq_i[7] = 0; vec_ack = 1; nx(); vec_ack = 0;
    nx(2);
    summary();
  end

endmodule